// File: doc/BRIEF.md
# Wiper Tap Selector

This block holds the position of one resistor-ladder wiper as an 8-bit code and turns that code into a one-hot enable vector for the 256 tap switches of the ladder. Tap 0 sits at the low terminal and tap 255 sits at the high terminal. Each channel of a multi-channel trimmer instantiates one copy.

The code can change in four ways. The host can write a byte directly. The code can be copied from one of four stored setting bytes. It can be stepped by one position up or down, and it holds at either end. It is also loaded from setting 0 automatically once reset ends. The serial front end and the storage of the setting bytes sit outside the block. Requests arrive as single-cycle strobes with their data, and the four setting bytes are inputs that are always valid.

Top module: `wiper_tap_select`

## Requirements
- R1: Outside the pre-reset interval, `tap_en_o` has exactly one bit set, and that bit has the index equal to `code_o`.
- R2: Code 0x00 drives only `tap_en_o[0]` (low terminal). Code 0xFF drives only `tap_en_o[255]` (high terminal).
- R3: While `rst_n` is low, at each clock edge `code_o` becomes 0x00, so only tap 0 is enabled. At the first rising clock edge after `rst_n` goes high, `code_o` loads setting 0, which is `set_data_i[7:0]`.
- R4: A `wr_req` strobe loads `wr_data` into `code_o` at the next rising edge.
- R5: An `xfer_req` strobe loads setting `xfer_sel` into `code_o` at the next rising edge. Setting n is `set_data_i[8n+7:8n]`.
- R6: A `step_req` strobe changes `code_o` by one at the next rising edge. `step_up`=1 adds one and `step_up`=0 subtracts one.
- R7: A step up at 0xFF leaves the code at 0xFF. A step down at 0x00 leaves the code at 0x00.
- R8: When requests coincide, the order of precedence is: the recall after reset, then `xfer_req`, then `wr_req`, then `step_req`. Requests that lose have no effect.
- R9: With no request and no recall, `code_o` and `tap_en_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| set_data_i | input | 32 | Four stored setting bytes; setting n is bits [8n+7:8n] |
| xfer_req | input | 1 | Copy a stored setting into the wiper code |
| xfer_sel | input | 2 | Index of the setting to copy |
| wr_req | input | 1 | Direct write strobe |
| wr_data | input | 8 | Byte for a direct write |
| step_req | input | 1 | Single-position step strobe |
| step_up | input | 1 | Step direction: 1 moves toward the high terminal |
| code_o | output | 8 | Current wiper code |
| tap_en_o | output | 256 | One-hot tap switch enables |

## Verification
The decoder works directly from the code register, so a wrong code appears on both outputs at the rising edge that loaded it. A wrong decode appears on the tap vector in that same cycle. A missed recall or a mis-ordered precedence shows up as the wrong byte one edge after the request. A wrap instead of saturation shows the opposite end of the ladder after a single step. The bench compares the code and the full tap vector after every edge it drives.

// File: rtl/wiper_pkg.sv
// Shared types for the wiper tap selector.
// Assumes one wiper code per channel; the width is set by the top parameter.
package wiper_pkg;

    // Source that updates the wiper code in a given cycle
    typedef enum logic [2:0] {
        SRC_HOLD   = 3'd0,
        SRC_RECALL = 3'd1,
        SRC_XFER   = 3'd2,
        SRC_WRITE  = 3'd3,
        SRC_STEP   = 3'd4
    } load_src_e;

endpackage

// File: rtl/wiper_step.sv
// Saturating one-position stepper.
// Computes code +1 or -1 and clamps at the all-ones and all-zeros ends.
// Assumes the caller decides whether the result is used.
module wiper_step #(
    parameter int CODE_W = 8
) (
    input  logic [CODE_W-1:0] cur_i,
    input  logic              up_i,
    output logic [CODE_W-1:0] next_o
);
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] CODE_MIN = '0;

    // Step by one toward the chosen end, holding at that end
    always_comb begin
        if (up_i) begin
            next_o = (cur_i == CODE_MAX) ? CODE_MAX : cur_i + CODE_W'(1);
        end else begin
            next_o = (cur_i == CODE_MIN) ? CODE_MIN : cur_i - CODE_W'(1);
        end
    end
endmodule

// File: rtl/wiper_load_arb.sv
// Fixed-priority selector for the next wiper code.
// Order: recall of setting 0, transfer from a setting, direct write, step.
// Assumes the settings arrive as one flat vector, setting n at [n*CODE_W +: CODE_W].
module wiper_load_arb
    import wiper_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int NUM_SET = 4,
    localparam int SEL_W = (NUM_SET > 1) ? $clog2(NUM_SET) : 1
) (
    input  logic [NUM_SET*CODE_W-1:0] set_data_i,
    input  logic                      recall_i,
    input  logic                      xfer_i,
    input  logic [SEL_W-1:0]          xfer_sel_i,
    input  logic                      wr_i,
    input  logic [CODE_W-1:0]         wr_data_i,
    input  logic                      step_i,
    input  logic [CODE_W-1:0]         step_val_i,
    input  logic [CODE_W-1:0]         cur_i,
    output logic [CODE_W-1:0]         next_o,
    output load_src_e                 src_o
);
    logic [CODE_W-1:0] set_word [NUM_SET];
    logic [CODE_W-1:0] xfer_word;

    // Split the flat setting vector into one word per setting
    for (genvar g = 0; g < NUM_SET; g++) begin : g_split
        assign set_word[g] = set_data_i[g*CODE_W +: CODE_W];
    end

    // Pick the addressed setting; an index past the last one reads setting 0
    always_comb begin
        xfer_word = set_word[0];
        for (int i = 0; i < NUM_SET; i++) begin
            if (xfer_sel_i == SEL_W'(i)) xfer_word = set_word[i];
        end
    end

    // Resolve the highest-priority request into a source tag
    always_comb begin
        if (recall_i)      src_o = SRC_RECALL;
        else if (xfer_i)   src_o = SRC_XFER;
        else if (wr_i)     src_o = SRC_WRITE;
        else if (step_i)   src_o = SRC_STEP;
        else               src_o = SRC_HOLD;
    end

    // Route the data of the winning source to the next code
    always_comb begin
        unique case (src_o)
            SRC_RECALL: next_o = set_word[0];
            SRC_XFER:   next_o = xfer_word;
            SRC_WRITE:  next_o = wr_data_i;
            SRC_STEP:   next_o = step_val_i;
            default:    next_o = cur_i;
        endcase
    end
endmodule

// File: rtl/wiper_tap_decode.sv
// One-hot tap decoder.
// Drives enable bit i when the code equals i, so exactly one bit is set for any
// defined code. Bit 0 is the low terminal and the top bit is the high terminal.
module wiper_tap_decode #(
    parameter int CODE_W = 8,
    localparam int NUM_TAPS = 1 << CODE_W
) (
    input  logic [CODE_W-1:0]   code_i,
    output logic [NUM_TAPS-1:0] tap_en_o
);
    // One comparator per tap switch
    for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
        assign tap_en_o[t] = (code_i == CODE_W'(t));
    end
endmodule

// File: rtl/wiper_tap_select.sv
// Wiper code register with a one-hot tap decoder, one per ladder channel.
// Holds the wiper code and loads it from the recall of setting 0 (in the first
// cycle after reset), a setting transfer, a direct write or a saturating step.
// Assumes single-cycle request strobes and settings that are always valid.
// The reset is synchronous and active low, and it parks the wiper at tap 0.
module wiper_tap_select
    import wiper_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int NUM_SET = 4,
    localparam int NUM_TAPS = 1 << CODE_W,
    localparam int SEL_W = (NUM_SET > 1) ? $clog2(NUM_SET) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SET*CODE_W-1:0] set_data_i,
    input  logic                      xfer_req,
    input  logic [SEL_W-1:0]          xfer_sel,
    input  logic                      wr_req,
    input  logic [CODE_W-1:0]         wr_data,
    input  logic                      step_req,
    input  logic                      step_up,
    output logic [CODE_W-1:0]         code_o,
    output logic [NUM_TAPS-1:0]       tap_en_o
);
    logic              recall_pend;
    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] code_d;
    logic [CODE_W-1:0] step_val;
    load_src_e         src;

    // Arm the recall during reset; it fires once in the first cycle after reset
    always_ff @(posedge clk) begin
        if (!rst_n) recall_pend <= 1'b1;
        else        recall_pend <= 1'b0;
    end

    // Wiper code register, parked at the low terminal during reset
    always_ff @(posedge clk) begin
        if (!rst_n) code_q <= '0;
        else        code_q <= code_d;
    end

    wiper_step #(.CODE_W(CODE_W)) u_step (
        .cur_i  (code_q),
        .up_i   (step_up),
        .next_o (step_val)
    );

    wiper_load_arb #(.CODE_W(CODE_W), .NUM_SET(NUM_SET)) u_arb (
        .set_data_i (set_data_i),
        .recall_i   (recall_pend),
        .xfer_i     (xfer_req),
        .xfer_sel_i (xfer_sel),
        .wr_i       (wr_req),
        .wr_data_i  (wr_data),
        .step_i     (step_req),
        .step_val_i (step_val),
        .cur_i      (code_q),
        .next_o     (code_d),
        .src_o      (src)
    );

    wiper_tap_decode #(.CODE_W(CODE_W)) u_dec (
        .code_i   (code_q),
        .tap_en_o (tap_en_o)
    );

    assign code_o = code_q;

    // Keep the source tag for debug visibility without another output port
    logic src_unused;
    assign src_unused = ^src;
endmodule

// File: rtl/wiper_tap_select_chk.sv
// Property checker for the wiper tap selector, attached by bind.
// Keeps its own flag for the recall cycle after reset.
module wiper_tap_select_chk #(
    parameter int CODE_W = 8,
    parameter int NUM_SET = 4,
    localparam int NUM_TAPS = 1 << CODE_W,
    localparam int SEL_W = (NUM_SET > 1) ? $clog2(NUM_SET) : 1
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NUM_SET*CODE_W-1:0] set_data_i,
    input logic                      xfer_req,
    input logic [SEL_W-1:0]          xfer_sel,
    input logic                      wr_req,
    input logic [CODE_W-1:0]         wr_data,
    input logic                      step_req,
    input logic                      step_up,
    input logic [CODE_W-1:0]         code_o,
    input logic [NUM_TAPS-1:0]       tap_en_o
);
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

    logic settled;

    // Low only in reset and in the recall cycle right after it
    always_ff @(posedge clk) begin
        if (!rst_n) settled <= 1'b0;
        else        settled <= 1'b1;
    end

    AST_ONE_TAP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tap_en_o) == 1); // R1
    AST_TAP_AT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        tap_en_o[code_o] == 1'b1); // R1
    AST_LOW_END: assert property (@(posedge clk) disable iff (!rst_n)
        (code_o == '0) |-> tap_en_o[0]); // R2
    AST_HIGH_END: assert property (@(posedge clk) disable iff (!rst_n)
        (code_o == CODE_MAX) |-> tap_en_o[NUM_TAPS-1]); // R2
    AST_RECALL: assert property (@(posedge clk) disable iff (!rst_n)
        !settled |=> code_o == $past(set_data_i[CODE_W-1:0])); // R3
    AST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && wr_req && !xfer_req) |=> code_o == $past(wr_data)); // R4
    AST_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && xfer_req) |=> code_o == $past(set_data_i[xfer_sel*CODE_W +: CODE_W])); // R5
    AST_STEP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && step_req && step_up && !wr_req && !xfer_req && code_o == CODE_MAX)
        |=> code_o == CODE_MAX); // R7
    AST_STEP_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && step_req && !step_up && !wr_req && !xfer_req && code_o == '0)
        |=> code_o == '0); // R7
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && !step_req && !wr_req && !xfer_req) |=> $stable(code_o)); // R9
endmodule

bind wiper_tap_select wiper_tap_select_chk #(.CODE_W(CODE_W), .NUM_SET(NUM_SET)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_data_i (set_data_i),
    .xfer_req   (xfer_req),
    .xfer_sel   (xfer_sel),
    .wr_req     (wr_req),
    .wr_data    (wr_data),
    .step_req   (step_req),
    .step_up    (step_up),
    .code_o     (code_o),
    .tap_en_o   (tap_en_o)
);

// File: tb/wiper_tap_select_test.sv
// Bench for the wiper tap selector: a vector table, then directed reset and
// precedence cases. Inputs change on falling edges and outputs are sampled 1 ns
// after the rising edge.
module wiper_tap_select_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [31:0]  set_data_i;
    logic         xfer_req = 1'b0;
    logic [1:0]   xfer_sel = '0;
    logic         wr_req = 1'b0;
    logic [7:0]   wr_data = '0;
    logic         step_req = 1'b0;
    logic         step_up = 1'b0;
    logic [7:0]   code_o;
    logic [255:0] tap_en_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    wiper_tap_select uut (
        .clk(clk), .rst_n(rst_n), .set_data_i(set_data_i),
        .xfer_req(xfer_req), .xfer_sel(xfer_sel),
        .wr_req(wr_req), .wr_data(wr_data),
        .step_req(step_req), .step_up(step_up),
        .code_o(code_o), .tap_en_o(tap_en_o)
    );

    typedef struct packed {
        logic       xf;
        logic [1:0] sel;
        logic       wr;
        logic [7:0] wd;
        logic       st;
        logic       up;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    // Settings: s0=5A s1=01 s2=FE s3=80. The run starts at 5A after the recall.
    localparam vec_t VECS [13] = '{
        '{1'b0, 2'd0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h5A, 4'd9},
        '{1'b0, 2'd0, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 4'd4},
        '{1'b0, 2'd0, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 4'd7},
        '{1'b0, 2'd0, 1'b0, 8'h00, 1'b1, 1'b1, 8'h01, 4'd6},
        '{1'b1, 2'd2, 1'b0, 8'h00, 1'b0, 1'b0, 8'hFE, 4'd5},
        '{1'b0, 2'd0, 1'b0, 8'h00, 1'b1, 1'b1, 8'hFF, 4'd6},
        '{1'b0, 2'd0, 1'b0, 8'h00, 1'b1, 1'b1, 8'hFF, 4'd7},
        '{1'b0, 2'd0, 1'b0, 8'h00, 1'b1, 1'b0, 8'hFE, 4'd6},
        '{1'b1, 2'd3, 1'b1, 8'h33, 1'b0, 1'b0, 8'h80, 4'd8},
        '{1'b0, 2'd0, 1'b1, 8'h33, 1'b1, 1'b1, 8'h33, 4'd8},
        '{1'b1, 2'd1, 1'b0, 8'h00, 1'b1, 1'b0, 8'h01, 4'd8},
        '{1'b0, 2'd0, 1'b1, 8'hFF, 1'b0, 1'b0, 8'hFF, 4'd4},
        '{1'b1, 2'd0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h5A, 4'd5}
    };

    task automatic chk(input logic [7:0] exp, input string req);
        logic [255:0] exp_taps;
        exp_taps = 256'(1) << exp;
        n_cmp += 2;
        if (code_o !== exp) begin
            n_bad++;
            $display("FAIL %s code actual=%h expected=%h", req, code_o, exp);
        end
        if (tap_en_o !== exp_taps) begin
            n_bad++;
            $display("FAIL %s taps actual=%h expected=%h (R1/R2)", req, tap_en_o, exp_taps);
        end
    endtask

    task automatic drive(input logic xf, input logic [1:0] sel, input logic wr,
                         input logic [7:0] wd, input logic st, input logic up);
        @(negedge clk);
        xfer_req = xf; xfer_sel = sel; wr_req = wr; wr_data = wd;
        step_req = st; step_up = up;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        set_data_i = {8'h80, 8'hFE, 8'h01, 8'h5A};
        // R3: reset state, wiper parked at tap 0
        repeat (3) @(posedge clk);
        #1;
        chk(8'h00, "R3 reset");
        // R3, R8: recall wins over coincident transfer and write in its cycle
        @(negedge clk);
        rst_n = 1'b1;
        xfer_req = 1'b1; xfer_sel = 2'd2; wr_req = 1'b1; wr_data = 8'h77;
        @(posedge clk);
        #1;
        chk(8'h5A, "R3 R8 recall");
        drive(1'b0, 2'd0, 1'b0, 8'h00, 1'b0, 1'b0);
        chk(8'h5A, "R9 hold after recall");

        for (int i = 0; i < 13; i++) begin
            drive(VECS[i].xf, VECS[i].sel, VECS[i].wr, VECS[i].wd, VECS[i].st, VECS[i].up);
            chk(VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i));
        end

        // R9: several idle cycles keep the code
        repeat (3) begin
            drive(1'b0, 2'd0, 1'b0, 8'h00, 1'b0, 1'b0);
            chk(8'h5A, "R9 idle");
        end
        // R9: a change to the settings alone does not move the wiper
        @(negedge clk);
        set_data_i = {8'h80, 8'hFE, 8'h01, 8'hC3};
        drive(1'b0, 2'd0, 1'b0, 8'h00, 1'b0, 1'b0);
        chk(8'h5A, "R9 settings change");

        // R3: a reset in mid-run parks at 0, then recalls the new setting 0
        drive(1'b0, 2'd0, 1'b1, 8'h10, 1'b0, 1'b0);
        chk(8'h10, "R4 write");
        @(negedge clk);
        rst_n = 1'b0;
        wr_req = 1'b0;
        @(posedge clk);
        #1;
        chk(8'h00, "R3 mid-run reset");
        @(negedge clk);
        rst_n = 1'b1;
        step_req = 1'b1; step_up = 1'b1;
        @(posedge clk);
        #1;
        chk(8'hC3, "R3 R8 recall over step");
        drive(1'b0, 2'd0, 1'b0, 8'h00, 1'b1, 1'b1);
        chk(8'hC4, "R6 step up");
        drive(1'b0, 2'd0, 1'b0, 8'h00, 1'b0, 1'b0);
        finish_run();
    end
endmodule